// File: doc/BRIEF.md
# Cluster Instruction Steering Unit

This block decides, for every instruction leaving the rename stage, which of eight execution clusters should receive it. Each cluster gets a score built from four contributions: locality (the cluster produces one of the instruction's source operands), producer criticality (that producer has been on the critical path before), free issue-queue capacity, and, for loads, nearness to the cache bank the address predictor expects. The cluster with the largest score is the first choice.

When that first choice lacks a free issue-queue entry or a free physical register, the unit walks outward around the cluster ring and takes the closest cluster that has both. If no cluster has room, it raises a stall instead of an assignment. The decision is registered, so it appears one clock after the request.

Top module: `cluster_steer`

## Requirements
- R1: Each valid source operand whose producer ID equals a cluster's index adds 4 to that cluster's score.
- R2: A matching valid source operand whose critical-path history bit is 1 adds a further 2 to its producer cluster's score.
- R3: Every cluster's score includes 1 for each free issue-queue entry it reports.
- R4: When the load flag is 1, the four clusters that share the predicted bank get 3 more (clusters 0 to 3 share bank 0, clusters 4 to 7 share bank 1). When the load flag is 0, the bank input has no effect.
- R5: The first choice is the cluster with the highest score. A tie goes to the lowest cluster index.
- R6: Scores saturate at 255 and never wrap.
- R7: When the first choice has zero free issue-queue entries or zero free registers, the assignment goes to the first cluster with both that appears in the order first+1, first-1, first+2, first-2, and so on, taken modulo 8.
- R8: A request in a cycle where no cluster has both resources gives stall=1 and valid=0 on the next cycle.
- R9: Outputs are registered. A request in cycle n shows on the outputs in cycle n+1. A cycle with no request gives valid=0 and stall=0 next cycle. Valid and stall are never 1 together.
- R10: While reset is held low, valid=0, stall=0 and cluster=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An instruction is presented for steering |
| src_vld | input | 2 | Per-source operand valid |
| src_cid | input | 6 | Per-source producer cluster ID, 3 bits each, source 0 in bits 2:0 |
| src_crit | input | 2 | Per-source critical-path history bit |
| is_load | input | 1 | Instruction is a load |
| pred_bank | input | 1 | Predicted cache bank for the load |
| iq_free | input | 64 | Free issue-queue entries per cluster, 8 bits each, cluster 0 in bits 7:0 |
| reg_free | input | 64 | Free physical registers per cluster, 8 bits each, cluster 0 in bits 7:0 |
| out_valid | output | 1 | Assignment valid |
| out_cluster | output | 3 | Assigned cluster |
| out_stall | output | 1 | No cluster has room for the request |

## Verification
The assertions check the following on every cycle:
- The first choice has the top score and no lower index ties it.
- A valid assignment always names a cluster that had both resources in the request cycle.
- A stall only follows a cycle in which every cluster lacked room.
- Any output activity traces back to a request, and valid and stall never assert together.

The exact weight values, saturation, load-bank proximity and the outward order of the fallback search can only be shown by the bench's directed scenarios, which compare the chosen cluster with hand-worked scores.

// File: rtl/steer_pkg.sv
package steer_pkg;
  parameter int SCORE_W = 8;
  typedef logic [SCORE_W-1:0] score_t;

  // Clamp a wide raw sum into the score range.
  function automatic score_t sat_score(input logic [31:0] raw);
    if (raw > 32'((1 << SCORE_W) - 1)) return {SCORE_W{1'b1}};
    return raw[SCORE_W-1:0];
  endfunction
endpackage

// File: rtl/steer_score.sv
module steer_score
  import steer_pkg::*;
#(
  parameter int IDX    = 0,
  parameter int N      = 8,
  parameter int NSRC   = 2,
  parameter int CID_W  = 3,
  parameter int CNT_W  = 8,
  parameter int NBANK  = 2,
  parameter int BANK_W = 1,
  parameter int OP_W   = 4,
  parameter int CRIT_W = 2,
  parameter int FREE_W = 1,
  parameter int LOAD_W = 3
) (
  input  logic [NSRC-1:0]       src_vld,
  input  logic [NSRC*CID_W-1:0] src_cid,
  input  logic [NSRC-1:0]       src_crit,
  input  logic                  is_load,
  input  logic [BANK_W-1:0]     pred_bank,
  input  logic [CNT_W-1:0]      iq_free,
  output score_t                score
);
  localparam int PER_BANK = N / NBANK;
  localparam int MY_BANK  = IDX / PER_BANK;

  logic near_bank;
  logic [31:0] raw;

  assign near_bank = (pred_bank == BANK_W'(MY_BANK));

  always_comb begin
    raw = 32'(iq_free) * 32'(FREE_W);
    for (int s = 0; s < NSRC; s++) begin
      if (src_vld[s] && (src_cid[s*CID_W +: CID_W] == CID_W'(IDX))) begin
        raw = raw + 32'(OP_W);
        if (src_crit[s]) raw = raw + 32'(CRIT_W);
      end
    end
    if (is_load && near_bank) raw = raw + 32'(LOAD_W);
    score = sat_score(raw);
  end
endmodule

// File: rtl/steer_argmax.sv
module steer_argmax
  import steer_pkg::*;
#(
  parameter int N     = 8,
  parameter int CID_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N*SCORE_W-1:0] scores,
  output logic [CID_W-1:0]     win,
  output score_t               win_score
);
  always_comb begin
    win       = '0;
    win_score = scores[SCORE_W-1:0];
    for (int i = 1; i < N; i++) begin
      if (scores[i*SCORE_W +: SCORE_W] > win_score) begin
        win       = CID_W'(i);
        win_score = scores[i*SCORE_W +: SCORE_W];
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    a_r5_top_score: assert property (@(posedge clk) disable iff (!rst_n)
      scores[g*SCORE_W +: SCORE_W] <= win_score);
    a_r5_low_tie: assert property (@(posedge clk) disable iff (!rst_n)
      (CID_W'(g) < win) |-> (scores[g*SCORE_W +: SCORE_W] < win_score));
  end
endmodule

// File: rtl/steer_fallback.sv
module steer_fallback #(
  parameter int N     = 8,
  parameter int CID_W = 3
) (
  input  logic [CID_W-1:0] win,
  input  logic [N-1:0]     room,
  output logic [CID_W-1:0] pick,
  output logic             any_room
);
  logic found;
  logic [CID_W-1:0] up_c, dn_c;

  always_comb begin
    pick  = win;
    found = room[win];
    up_c  = win;
    dn_c  = win;
    for (int d = 1; d <= N / 2; d++) begin
      up_c = CID_W'(win + CID_W'(d));
      dn_c = CID_W'(win - CID_W'(d));
      if (!found && room[up_c]) begin
        pick  = up_c;
        found = 1'b1;
      end
      if (!found && room[dn_c]) begin
        pick  = dn_c;
        found = 1'b1;
      end
    end
    any_room = |room;
  end
endmodule

// File: rtl/cluster_steer.sv
module cluster_steer
  import steer_pkg::*;
#(
  parameter int N      = 8,
  parameter int NSRC   = 2,
  parameter int CNT_W  = 8,
  parameter int NBANK  = 2,
  parameter int OP_W   = 4,
  parameter int CRIT_W = 2,
  parameter int FREE_W = 1,
  parameter int LOAD_W = 3,
  localparam int CID_W  = $clog2(N),
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [NSRC-1:0]       src_vld,
  input  logic [NSRC*CID_W-1:0] src_cid,
  input  logic [NSRC-1:0]       src_crit,
  input  logic                  is_load,
  input  logic [BANK_W-1:0]     pred_bank,
  input  logic [N*CNT_W-1:0]    iq_free,
  input  logic [N*CNT_W-1:0]    reg_free,
  output logic                  out_valid,
  output logic [CID_W-1:0]      out_cluster,
  output logic                  out_stall
);
  logic [N*SCORE_W-1:0] scores;
  logic [N-1:0]         room;
  logic [CID_W-1:0]     first_pick;
  score_t               first_score;
  logic [CID_W-1:0]     final_pick;
  logic                 any_room;

  for (genvar c = 0; c < N; c++) begin : g_cl
    steer_score #(
      .IDX(c), .N(N), .NSRC(NSRC), .CID_W(CID_W), .CNT_W(CNT_W),
      .NBANK(NBANK), .BANK_W(BANK_W), .OP_W(OP_W), .CRIT_W(CRIT_W),
      .FREE_W(FREE_W), .LOAD_W(LOAD_W)
    ) u_score (
      .src_vld  (src_vld),
      .src_cid  (src_cid),
      .src_crit (src_crit),
      .is_load  (is_load),
      .pred_bank(pred_bank),
      .iq_free  (iq_free[c*CNT_W +: CNT_W]),
      .score    (scores[c*SCORE_W +: SCORE_W])
    );
    assign room[c] = (iq_free[c*CNT_W +: CNT_W] != '0) &&
                     (reg_free[c*CNT_W +: CNT_W] != '0);
  end

  steer_argmax #(.N(N), .CID_W(CID_W)) u_argmax (
    .clk      (clk),
    .rst_n    (rst_n),
    .scores   (scores),
    .win      (first_pick),
    .win_score(first_score)
  );

  steer_fallback #(.N(N), .CID_W(CID_W)) u_fallback (
    .win     (first_pick),
    .room    (room),
    .pick    (final_pick),
    .any_room(any_room)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_stall   <= 1'b0;
      out_cluster <= '0;
    end else begin
      out_valid <= req_valid && any_room;
      out_stall <= req_valid && !any_room;
      if (req_valid && any_room) out_cluster <= final_pick;
    end
  end

  // R7: an assignment lands only on a cluster that had room
  a_r7_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((($past(room) >> out_cluster) & N'(1)) != '0));
  a_r8_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    out_stall |-> ($past(room) == '0));
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_stall));
  a_r9_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_stall) |-> $past(req_valid));
endmodule

// File: tb/sim_cluster_steer.sv
module sim_cluster_steer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] src_vld = '0;
  logic [5:0] src_cid = '0;
  logic [1:0] src_crit = '0;
  logic is_load = 1'b0;
  logic [0:0] pred_bank = '0;
  logic [63:0] iq_free, reg_free;
  logic out_valid, out_stall;
  logic [2:0] out_cluster;

  logic [7:0] iq [8];
  logic [7:0] rg [8];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int c = 0; c < 8; c++) begin
      iq_free[c*8 +: 8]  = iq[c];
      reg_free[c*8 +: 8] = rg[c];
    end

  cluster_steer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .src_vld(src_vld),
    .src_cid(src_cid), .src_crit(src_crit), .is_load(is_load),
    .pred_bank(pred_bank), .iq_free(iq_free), .reg_free(reg_free),
    .out_valid(out_valid), .out_cluster(out_cluster), .out_stall(out_stall)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic base(input int f);
    for (int c = 0; c < 8; c++) begin iq[c] = 8'(f); rg[c] = 8'(f); end
    src_vld = '0; src_cid = '0; src_crit = '0; is_load = 1'b0; pred_bank = '0;
  endtask

  // Present one request, then sample after the registering edge.
  task automatic steer(input string req, input int exp_cl);
    req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " cluster"}, int'(out_cluster), exp_cl);
  endtask

  task automatic t_reset();
    chk("R10 valid", int'(out_valid), 0);
    chk("R10 stall", int'(out_stall), 0);
    chk("R10 cluster", int'(out_cluster), 0);
  endtask

  task automatic t_operand();
    base(2); src_vld = 2'b01; src_cid = {3'd0, 3'd5};
    steer("R1 single", 5);
    base(2); src_vld = 2'b11; src_cid = {3'd6, 3'd6}; iq[1] = 9;
    steer("R1 two ops 10 beats 9", 6);
  endtask

  task automatic t_crit();
    base(2); src_vld = 2'b11; src_cid = {3'd6, 3'd3}; src_crit = 2'b10;
    steer("R2 critical wins", 6);
  endtask

  task automatic t_free();
    base(2); iq[4] = 9;
    steer("R3 most free", 4);
    base(2); iq[7] = 5; src_vld = 2'b01; src_cid = {3'd0, 3'd1};
    steer("R3 operand 6 beats free 5", 1);
  endtask

  task automatic t_load();
    base(2); is_load = 1'b1; pred_bank = 1'b1;
    steer("R4 bank1 group", 4);
    base(2); is_load = 1'b1; pred_bank = 1'b0; iq[2] = 4;
    steer("R4 bank0 group", 2);
    base(2); is_load = 1'b1; pred_bank = 1'b1; iq[1] = 4;
    steer("R4 far cluster not favoured", 4);
    base(2); is_load = 1'b0; pred_bank = 1'b1; iq[1] = 3;
    steer("R4 bank ignored for non-load", 1);
  endtask

  task automatic t_tie();
    base(3);
    steer("R5 all equal", 0);
    base(3); src_vld = 2'b11; src_cid = {3'd6, 3'd2};
    steer("R5 tie lowest", 2);
  endtask

  task automatic t_sat();
    base(2); iq[5] = 250; src_vld = 2'b11; src_cid = {3'd5, 3'd5};
    src_crit = 2'b11; iq[1] = 10;
    steer("R6 no wrap", 5);
    base(2); iq[5] = 250; src_vld = 2'b11; src_cid = {3'd5, 3'd5};
    src_crit = 2'b11; iq[1] = 255;
    steer("R6 clamp then tie", 1);
  endtask

  task automatic t_fallback();
    base(2); src_vld = 2'b01; src_cid = {3'd0, 3'd4}; rg[4] = 0;
    steer("R7 plus one", 5);
    base(2); src_vld = 2'b01; src_cid = {3'd0, 3'd4}; rg[4] = 0; rg[5] = 0;
    steer("R7 minus one", 3);
    base(2); src_vld = 2'b01; src_cid = {3'd0, 3'd4}; rg[4] = 0; rg[5] = 0; iq[3] = 0;
    steer("R7 distance two", 6);
    base(2); src_vld = 2'b01; src_cid = {3'd0, 3'd0}; iq[0] = 0; rg[1] = 0;
    steer("R7 wrap", 7);
  endtask

  task automatic t_stall();
    base(2); for (int c = 0; c < 8; c++) rg[c] = 0;
    req_valid = 1'b1; @(posedge clk); @(negedge clk); req_valid = 1'b0;
    chk("R8 stall", int'(out_stall), 1);
    chk("R8 no valid", int'(out_valid), 0);
    base(2); for (int c = 0; c < 8; c++) iq[c] = 0;
    req_valid = 1'b1; @(posedge clk); @(negedge clk); req_valid = 1'b0;
    chk("R8 stall iq empty", int'(out_stall), 1);
  endtask

  task automatic t_idle();
    base(2); iq[3] = 7;
    steer("R9 request", 3);
    @(posedge clk); @(negedge clk);
    chk("R9 idle valid", int'(out_valid), 0);
    chk("R9 idle stall", int'(out_stall), 0);
    req_valid = 1'b1; #1;
    chk("R9 not before edge", int'(out_valid), 0);
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    chk("R9 after edge", int'(out_valid), 1);
  endtask

  initial begin
    base(2);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_operand();
    t_crit();
    t_free();
    t_load();
    t_tie();
    t_sat();
    t_fallback();
    t_stall();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule